// File: doc/BRIEF.md
# Command-to-AXI4-Lite Master Bridge

This block lets user logic that speaks a simple command/acknowledge protocol reach AXI4-Lite slaves. The user pulses a read or a write request for one cycle, together with an address, byte enables and (for writes) the data. The bridge copies the command into its registers, runs a single-beat transfer on the AXI4-Lite channels, and reports back with a one-cycle acknowledge once the slave has taken the address. A one-cycle completion follows once the transfer has finished, with an error flag beside it.

Read data comes back with an active-low source-ready strobe. For a write, an active-low destination-ready strobe tells the user that the slave has taken its data beat. A separate master-error output latches on any slave or decode error. Only the hard reset or the user-side local reset clears it. Only one command is in flight at a time. Both bus widths are parameters, with 32 bits as the default.

Top module: `axil_cmd_bridge`

## Requirements
- R1: After a synchronous active-high `rst` (or `usr_rst`) is sampled, the following take their reset values on the next clock:
  - all AXI valid and ready outputs are 0;
  - `cmd_ack`, `cmd_done` and `cmd_err` are 0;
  - both active-low strobes are 1;
  - addresses, write data and `rd_dout` are zero;
  - `m_wstrb` is all ones;
  - `md_error` is 0.
- R2: A read request drives `m_arvalid` with the latched address and raises `m_rready` once the address has been accepted. On the R handshake, `rd_dout` carries RDATA, and `rd_src_rdy_n` is low for exactly the one cycle in which `cmd_done` is high.
- R3: A write request raises `m_awvalid` and `m_wvalid` together, with `m_wdata` = the write data and `m_wstrb` = `cmd_be`. `wr_dst_rdy_n` is low for one cycle right after the W handshake.
- R4: `cmd_ack` is high for exactly one cycle per command, in the cycle after the address-channel handshake.
- R5: `m_bready` rises after both the AW and the W handshakes and is held until BVALID. `cmd_done` pulses in the cycle after the response handshake (R or B).
- R6: `cmd_err` is high together with `cmd_done` exactly when the response is 10b or 11b. A response of 00b or 01b gives no error.
- R7: `md_error` sets together with the erroring completion and stays set until `rst` or `usr_rst` is sampled high.
- R8: Only one command is accepted at a time. Requests that arrive while a transfer is outstanding are dropped. When read and write are requested in the same cycle, the read is taken and the write is discarded.
- R9: `cmd_be` has no effect on reads: `m_wstrb` keeps the strobes of the last write. `cmd_lock` has no effect on any transfer.
- R10: `m_arprot` and `m_awprot` are always 000b. `cmd_rearb` and `cmd_tmo` are always 0.
- R11: A reset during a transfer abandons it. No completion is produced, and the outputs reach their reset values one clock after reset is sampled.
- R12: Each VALID, with its address or data, is held stable until its READY arrives, for any number of wait cycles. AWVALID and WVALID drop independently.
- R13: With a zero-wait slave, a command sampled at edge E0 shows `cmd_ack` after E1 and `cmd_done` after E2. For a write, `wr_dst_rdy_n` is also low after E1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| usr_rst | input | 1 | User-side local reset, also clears the sticky error |
| rd_req | input | 1 | Read request pulse |
| wr_req | input | 1 | Write request pulse |
| cmd_addr | input | ADDR_W | Command address |
| cmd_be | input | DATA_W/8 | Byte enables for writes |
| cmd_lock | input | 1 | Lock qualifier (ignored) |
| wr_data | input | DATA_W | Write data |
| cmd_ack | output | 1 | Address accepted pulse |
| cmd_done | output | 1 | Transfer complete pulse |
| cmd_err | output | 1 | Error response, valid with cmd_done |
| cmd_rearb | output | 1 | Rearbitrate, always 0 |
| cmd_tmo | output | 1 | Timeout, always 0 |
| rd_dout | output | DATA_W | Read data |
| rd_src_rdy_n | output | 1 | Active-low read data valid |
| wr_dst_rdy_n | output | 1 | Active-low write data taken |
| md_error | output | 1 | Sticky master-detected error |
| m_araddr | output | ADDR_W | AR address |
| m_arprot | output | 3 | AR protection, 000b |
| m_arvalid | output | 1 | AR valid |
| m_arready | input | 1 | AR ready |
| m_rdata | input | DATA_W | R data |
| m_rresp | input | 2 | R response |
| m_rvalid | input | 1 | R valid |
| m_rready | output | 1 | R ready |
| m_awaddr | output | ADDR_W | AW address |
| m_awprot | output | 3 | AW protection, 000b |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_wdata | output | DATA_W | W data |
| m_wstrb | output | DATA_W/8 | W strobes |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_bresp | input | 2 | B response |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready |

## Verification
The bench uses a slave whose AR, AW, W, R and B latencies are set independently. This finds a bridge that waits for AW and W to be accepted together: it would hang or send a duplicate beat when only one is delayed. A read and a write are requested in the same cycle, and a write is also requested while a read is stalled. A bridge that does not drop these requests would issue a second transfer or a second acknowledge. The EXOKAY response, and a run of clean transfers after an error, expose a sticky flag that clears itself or an error decode that looks at the wrong bit. A reset in the middle of a transfer, and the local reset, show whether a transfer is wrongly completed or the sticky error survives.

// File: rtl/acb_pkg.sv
package acb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_ADDR = 3'd1,
    ST_RD_DATA = 3'd2,
    ST_WR_SEND = 3'd3,
    ST_WR_RESP = 3'd4
  } acb_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  // Slave and decode errors count as faults; OKAY and EXOKAY do not.
  function automatic logic resp_is_fault(input logic [1:0] resp);
    return (resp == RESP_SLVERR) || (resp == RESP_DECERR);
  endfunction

endpackage

// File: rtl/acb_cmd_regs.sv
module acb_cmd_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_int,
  input  logic              rd_take,
  input  logic              wr_take,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [STRB_W-1:0] cmd_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [STRB_W-1:0] strb_q
);

  always_ff @(posedge clk) begin
    if (rst_int) begin
      addr_q <= '0;
      data_q <= '0;
      strb_q <= '1;
    end else if (rd_take) begin
      // strobes and data are left alone on reads
      addr_q <= cmd_addr;
    end else if (wr_take) begin
      addr_q <= cmd_addr;
      data_q <= wr_data;
      strb_q <= cmd_be;
    end
  end

endmodule

// File: rtl/acb_fsm.sv
module acb_fsm
  import acb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_int,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic              rd_take,
  output logic              wr_take,
  output logic              busy,
  output logic              fault_evt,
  output logic              cmd_ack,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic [DATA_W-1:0] rd_dout,
  output logic              rd_src_rdy_n,
  output logic              wr_dst_rdy_n,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready
);

  acb_state_e state;
  logic aw_fin, w_fin, r_fire, b_fire;

  assign rd_take = (state == ST_IDLE) && rd_req;
  assign wr_take = (state == ST_IDLE) && wr_req && !rd_req;
  assign busy    = (state != ST_IDLE);

  assign r_fire = (state == ST_RD_DATA) && m_rvalid;
  assign b_fire = (state == ST_WR_RESP) && m_bvalid;
  // each write channel is finished when its valid is gone or is being taken now
  assign aw_fin = !m_awvalid || m_awready;
  assign w_fin  = !m_wvalid  || m_wready;

  assign fault_evt = (r_fire && resp_is_fault(m_rresp)) ||
                     (b_fire && resp_is_fault(m_bresp));

  always_ff @(posedge clk) begin
    if (rst_int) begin
      state        <= ST_IDLE;
      m_arvalid    <= 1'b0;
      m_rready     <= 1'b0;
      m_awvalid    <= 1'b0;
      m_wvalid     <= 1'b0;
      m_bready     <= 1'b0;
      cmd_ack      <= 1'b0;
      cmd_done     <= 1'b0;
      cmd_err      <= 1'b0;
      rd_dout      <= '0;
      rd_src_rdy_n <= 1'b1;
      wr_dst_rdy_n <= 1'b1;
    end else begin
      cmd_ack      <= 1'b0;
      cmd_done     <= 1'b0;
      cmd_err      <= 1'b0;
      rd_src_rdy_n <= 1'b1;
      wr_dst_rdy_n <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (rd_take) begin
            m_arvalid <= 1'b1;
            state     <= ST_RD_ADDR;
          end else if (wr_take) begin
            m_awvalid <= 1'b1;
            m_wvalid  <= 1'b1;
            state     <= ST_WR_SEND;
          end
        end
        ST_RD_ADDR: begin
          if (m_arready) begin
            m_arvalid <= 1'b0;
            m_rready  <= 1'b1;
            cmd_ack   <= 1'b1;
            state     <= ST_RD_DATA;
          end
        end
        ST_RD_DATA: begin
          if (r_fire) begin
            m_rready     <= 1'b0;
            rd_dout      <= m_rdata;
            rd_src_rdy_n <= 1'b0;
            cmd_done     <= 1'b1;
            cmd_err      <= resp_is_fault(m_rresp);
            state        <= ST_IDLE;
          end
        end
        ST_WR_SEND: begin
          if (m_awvalid && m_awready) begin
            m_awvalid <= 1'b0;
            cmd_ack   <= 1'b1;
          end
          if (m_wvalid && m_wready) begin
            m_wvalid     <= 1'b0;
            wr_dst_rdy_n <= 1'b0;
          end
          if (aw_fin && w_fin) begin
            m_bready <= 1'b1;
            state    <= ST_WR_RESP;
          end
        end
        ST_WR_RESP: begin
          if (b_fire) begin
            m_bready <= 1'b0;
            cmd_done <= 1'b1;
            cmd_err  <= resp_is_fault(m_bresp);
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/acb_sticky_err.sv
module acb_sticky_err (
  input  logic clk,
  input  logic rst,
  input  logic usr_rst,
  input  logic fault_evt,
  output logic md_error
);

  always_ff @(posedge clk) begin
    if (rst || usr_rst) md_error <= 1'b0;
    else if (fault_evt) md_error <= 1'b1;
  end

endmodule

// File: rtl/axil_cmd_bridge.sv
module axil_cmd_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usr_rst,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [STRB_W-1:0] cmd_be,
  input  logic              cmd_lock,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_ack,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic              cmd_rearb,
  output logic              cmd_tmo,
  output logic [DATA_W-1:0] rd_dout,
  output logic              rd_src_rdy_n,
  output logic              wr_dst_rdy_n,
  output logic              md_error,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [2:0]        m_arprot,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [2:0]        m_awprot,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready
);

  logic rst_int;
  logic rd_take, wr_take, busy, fault_evt;
  logic [ADDR_W-1:0] addr_q;

  assign rst_int   = rst || usr_rst;
  assign cmd_rearb = 1'b0;
  assign cmd_tmo   = 1'b0;
  assign m_arprot  = 3'b000;
  assign m_awprot  = 3'b000;
  assign m_araddr  = addr_q;
  assign m_awaddr  = addr_q;

  acb_cmd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_int  (rst_int),
    .rd_take  (rd_take),
    .wr_take  (wr_take),
    .cmd_addr (cmd_addr),
    .cmd_be   (cmd_be),
    .wr_data  (wr_data),
    .addr_q   (addr_q),
    .data_q   (m_wdata),
    .strb_q   (m_wstrb)
  );

  acb_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_int      (rst_int),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .rd_take      (rd_take),
    .wr_take      (wr_take),
    .busy         (busy),
    .fault_evt    (fault_evt),
    .cmd_ack      (cmd_ack),
    .cmd_done     (cmd_done),
    .cmd_err      (cmd_err),
    .rd_dout      (rd_dout),
    .rd_src_rdy_n (rd_src_rdy_n),
    .wr_dst_rdy_n (wr_dst_rdy_n),
    .m_arvalid    (m_arvalid),
    .m_arready    (m_arready),
    .m_rdata      (m_rdata),
    .m_rresp      (m_rresp),
    .m_rvalid     (m_rvalid),
    .m_rready     (m_rready),
    .m_awvalid    (m_awvalid),
    .m_awready    (m_awready),
    .m_wvalid     (m_wvalid),
    .m_wready     (m_wready),
    .m_bresp      (m_bresp),
    .m_bvalid     (m_bvalid),
    .m_bready     (m_bready)
  );

  acb_sticky_err u_sticky (
    .clk       (clk),
    .rst       (rst),
    .usr_rst   (usr_rst),
    .fault_evt (fault_evt),
    .md_error  (md_error)
  );

endmodule

// File: rtl/acb_checker.sv
module acb_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              usr_rst,
  input logic              rd_req,
  input logic              cmd_lock,
  input logic              busy,
  input logic              cmd_ack,
  input logic              cmd_done,
  input logic              cmd_err,
  input logic              rd_src_rdy_n,
  input logic              wr_dst_rdy_n,
  input logic              md_error,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [DATA_W-1:0] m_wdata,
  input logic [STRB_W-1:0] m_wstrb,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_bvalid,
  input logic              m_bready
);

  a_r12_ar_hold: assert property (@(posedge clk) disable iff (rst || usr_rst)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

  a_r12_aw_hold: assert property (@(posedge clk) disable iff (rst || usr_rst)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

  a_r12_w_hold: assert property (@(posedge clk) disable iff (rst || usr_rst)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));

  a_r4_ack_pulse: assert property (@(posedge clk) disable iff (rst || usr_rst)
    cmd_ack |=> !cmd_ack);

  a_r4_ack_after_addr: assert property (@(posedge clk) disable iff (rst || usr_rst)
    cmd_ack |-> $past((m_arvalid && m_arready) || (m_awvalid && m_awready)));

  a_r5_done_after_resp: assert property (@(posedge clk) disable iff (rst || usr_rst)
    cmd_done |-> $past((m_rvalid && m_rready) || (m_bvalid && m_bready)));

  a_r5_bready_held: assert property (@(posedge clk) disable iff (rst || usr_rst)
    (m_bready && !m_bvalid) |=> m_bready);

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (rst || usr_rst)
    cmd_err |-> cmd_done);

  a_r7_md_sticky: assert property (@(posedge clk) disable iff (rst)
    (md_error && !usr_rst) |=> md_error);

  a_r8_single_cmd: assert property (@(posedge clk) disable iff (rst || usr_rst)
    !(m_arvalid && (m_awvalid || m_wvalid)));

  a_r9_locked_read_issued: assert property (@(posedge clk) disable iff (rst || usr_rst)
    (rd_req && !busy && cmd_lock) |=> m_arvalid);

  a_r3_dst_after_w: assert property (@(posedge clk) disable iff (rst || usr_rst)
    !wr_dst_rdy_n |-> $past(m_wvalid && m_wready));

  a_r2_src_with_done: assert property (@(posedge clk) disable iff (rst || usr_rst)
    !rd_src_rdy_n |-> cmd_done);

endmodule

bind axil_cmd_bridge acb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .usr_rst      (usr_rst),
  .rd_req       (rd_req),
  .cmd_lock     (cmd_lock),
  .busy         (busy),
  .cmd_ack      (cmd_ack),
  .cmd_done     (cmd_done),
  .cmd_err      (cmd_err),
  .rd_src_rdy_n (rd_src_rdy_n),
  .wr_dst_rdy_n (wr_dst_rdy_n),
  .md_error     (md_error),
  .m_araddr     (m_araddr),
  .m_arvalid    (m_arvalid),
  .m_arready    (m_arready),
  .m_rvalid     (m_rvalid),
  .m_rready     (m_rready),
  .m_awaddr     (m_awaddr),
  .m_awvalid    (m_awvalid),
  .m_awready    (m_awready),
  .m_wdata      (m_wdata),
  .m_wstrb      (m_wstrb),
  .m_wvalid     (m_wvalid),
  .m_wready     (m_wready),
  .m_bvalid     (m_bvalid),
  .m_bready     (m_bready)
);

// File: tb/axil_cmd_bridge_test.sv
module axil_cmd_bridge_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, usr_rst = 1'b0, rd_req = 1'b0, wr_req = 1'b0, cmd_lock = 1'b0;
  logic [31:0] cmd_addr = '0, wr_data = '0;
  logic [3:0]  cmd_be = '0;
  logic cmd_ack, cmd_done, cmd_err, cmd_rearb, cmd_tmo, rd_src_rdy_n, wr_dst_rdy_n, md_error;
  logic [31:0] rd_dout, m_araddr, m_awaddr, m_wdata;
  logic [2:0]  m_arprot, m_awprot;
  logic [3:0]  m_wstrb;
  logic m_arvalid, m_rready, m_awvalid, m_wvalid, m_bready;
  logic m_arready = 1'b0, m_rvalid = 1'b0, m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [1:0]  m_rresp = '0, m_bresp = '0;

  axil_cmd_bridge uut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int s_ar_dly = 0, s_aw_dly = 0, s_w_dly = 0, s_r_dly = 0, s_b_dly = 0;
  logic [1:0]  s_resp = 2'b00;
  logic [31:0] s_rdata = '0;
  logic [31:0] sl_araddr = '0, sl_awaddr = '0, sl_wdata = '0;
  logic [3:0]  sl_wstrb = '0;

  initial begin
    int ar_w = 0, aw_w = 0, w_w = 0, r_w = 0, b_w = 0;
    logic r_pend = 0, b_pend = 0, aw_got = 0, w_got = 0;
    logic ar_hs, r_hs, aw_hs, w_hs, b_hs;
    forever begin
      @(posedge clk);
      ar_hs = m_arvalid && m_arready;
      r_hs  = m_rvalid && m_rready;
      aw_hs = m_awvalid && m_awready;
      w_hs  = m_wvalid && m_wready;
      b_hs  = m_bvalid && m_bready;
      if (ar_hs) sl_araddr = m_araddr;
      if (aw_hs) sl_awaddr = m_awaddr;
      if (w_hs) begin sl_wdata = m_wdata; sl_wstrb = m_wstrb; end
      @(negedge clk);
      if (rst || usr_rst) begin
        ar_w = 0; aw_w = 0; w_w = 0; r_w = 0; b_w = 0;
        r_pend = 0; b_pend = 0; aw_got = 0; w_got = 0;
        m_arready = 0; m_awready = 0; m_wready = 0; m_rvalid = 0; m_bvalid = 0;
      end else begin
        if (ar_hs) begin ar_w = 0; r_pend = 1; r_w = 0; end
        m_arready = m_arvalid && (ar_w >= s_ar_dly);
        if (m_arvalid && !m_arready) ar_w++;
        if (r_hs) begin r_pend = 0; m_rvalid = 0; end
        if (r_pend && !m_rvalid) begin
          if (r_w >= s_r_dly) begin m_rvalid = 1; m_rdata = s_rdata; m_rresp = s_resp; end
          else r_w++;
        end
        if (aw_hs) begin aw_got = 1; aw_w = 0; end
        if (w_hs) begin w_got = 1; w_w = 0; end
        if (aw_got && w_got) begin aw_got = 0; w_got = 0; b_pend = 1; b_w = 0; end
        m_awready = m_awvalid && (aw_w >= s_aw_dly);
        if (m_awvalid && !m_awready) aw_w++;
        m_wready = m_wvalid && (w_w >= s_w_dly);
        if (m_wvalid && !m_wready) w_w++;
        if (b_hs) begin b_pend = 0; m_bvalid = 0; end
        if (b_pend && !m_bvalid) begin
          if (b_w >= s_b_dly) begin m_bvalid = 1; m_bresp = s_resp; end
          else b_w++;
        end
      end
    end
  end

  // ---------------- transaction driver / monitor ----------------
  int r_n_ack, r_n_dst, r_n_ar, r_n_aw, r_n_w, r_k_ack, r_k_dst, r_k_done;
  logic r_done, r_err, r_src;
  logic [31:0] r_rd;
  logic [3:0]  r_wstrb0;

  task automatic run_cmd(input logic wr, input logic both, input logic lock,
                         input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                         input int inject_at);
    r_n_ack = 0; r_n_dst = 0; r_n_ar = 0; r_n_aw = 0; r_n_w = 0;
    r_k_ack = -1; r_k_dst = -1; r_k_done = -1;
    r_done = 0; r_err = 0; r_src = 1; r_rd = '0; r_wstrb0 = '0;
    @(negedge clk);
    cmd_addr = a; wr_data = d; cmd_be = be; cmd_lock = lock;
    rd_req = !wr || both; wr_req = wr || both;
    @(negedge clk);
    rd_req = 0; wr_req = 0; cmd_lock = 0;
    for (int k = 0; k < 300; k++) begin
      if (k == inject_at) begin
        wr_req = 1; cmd_addr = 32'h3000_0000; wr_data = 32'hFFFF_0000; cmd_be = 4'hF;
      end else begin
        wr_req = 0;
      end
      if (k == 0) r_wstrb0 = m_wstrb;
      if (cmd_ack) begin r_n_ack++; r_k_ack = k; end
      if (!wr_dst_rdy_n) begin r_n_dst++; r_k_dst = k; end
      if (m_arvalid) r_n_ar++;
      if (m_awvalid) r_n_aw++;
      if (m_wvalid) r_n_w++;
      if (cmd_done) begin
        r_done = 1; r_err = cmd_err; r_src = rd_src_rdy_n; r_rd = rd_dout; r_k_done = k;
        break;
      end
      @(negedge clk);
    end
    wr_req = 0;
  endtask

  // ---------------- vector table ----------------
  typedef struct packed {
    logic        wr;
    logic        lock;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic [3:0]  d_a;   // AR or AW wait cycles
    logic [3:0]  d_w;   // W wait cycles
    logic [3:0]  d_r;   // R or B wait cycles
    logic [1:0]  resp;
    logic        exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h1000_0004, 32'hDEAD_BEEF, 4'h0, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0},
    '{1'b1, 1'b0, 32'h2000_0010, 32'h1234_5678, 4'hF, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0},
    '{1'b1, 1'b0, 32'h2000_0020, 32'hA5A5_0F0F, 4'h5, 4'd3, 4'd0, 4'd2, 2'b00, 1'b0},
    '{1'b1, 1'b0, 32'h2000_0030, 32'h0BAD_F00D, 4'hE, 4'd0, 4'd4, 4'd0, 2'b01, 1'b0},
    '{1'b0, 1'b1, 32'h1000_0040, 32'hCAFE_1234, 4'hF, 4'd2, 4'd0, 4'd5, 2'b00, 1'b0},
    '{1'b0, 1'b0, 32'h1000_0050, 32'h5555_AAAA, 4'h0, 4'd1, 4'd0, 4'd1, 2'b10, 1'b1},
    '{1'b1, 1'b0, 32'h2000_0060, 32'h7777_8888, 4'h3, 4'd1, 4'd2, 4'd3, 2'b11, 1'b1},
    '{1'b0, 1'b0, 32'h1000_0070, 32'h0102_0304, 4'h8, 4'd0, 4'd0, 4'd0, 2'b00, 1'b0}
  };

  task automatic set_slave(input int da, input int dw, input int dr,
                           input logic [1:0] rsp, input logic [31:0] rdat);
    s_ar_dly = da; s_aw_dly = da; s_w_dly = dw; s_r_dly = dr; s_b_dly = dr;
    s_resp = rsp; s_rdata = rdat;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic md_exp;
    md_exp = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R10 reset state
    chk("R1", "valids/readies", {m_arvalid, m_awvalid, m_wvalid, m_rready, m_bready}, 5'b0);
    chk("R1", "pulses", {cmd_ack, cmd_done, cmd_err}, 3'b0);
    chk("R1", "strobes n", {rd_src_rdy_n, wr_dst_rdy_n}, 2'b11);
    chk("R1", "wstrb", m_wstrb, 4'hF);
    chk("R1", "addr/data", {m_araddr, m_wdata}, 64'h0);
    chk("R1", "md_error", md_error, 1'b0);
    chk("R10", "prot", {m_arprot, m_awprot}, 6'b0);
    chk("R10", "rearb/tmo", {cmd_rearb, cmd_tmo}, 2'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      set_slave(int'(v.d_a), int'(v.d_w), int'(v.d_r), v.resp, v.data);
      run_cmd(v.wr, 1'b0, v.lock, v.addr, v.data, v.be, -1);
      md_exp = md_exp | v.exp_err;
      chk(v.wr ? "R5" : "R2", "completion seen", r_done, 1'b1);
      chk("R4", "one ack", r_n_ack, 1);
      chk("R6", "error flag", r_err, v.exp_err);
      chk("R7", "md_error", md_error, md_exp);
      if (v.wr) begin
        chk("R3", "awaddr", sl_awaddr, v.addr);
        chk("R3", "wdata", sl_wdata, v.data);
        chk("R3", "wstrb", sl_wstrb, v.be);
        chk("R3", "one dst strobe", r_n_dst, 1);
        chk("R12", "awvalid cycles", r_n_aw, int'(v.d_a) + 1);
        chk("R12", "wvalid cycles", r_n_w, int'(v.d_w) + 1);
        chk("R2", "no src strobe on write", r_src, 1'b1);
      end else begin
        chk("R2", "araddr", sl_araddr, v.addr);
        chk("R2", "read data", r_rd, v.data);
        chk("R2", "src strobe low", r_src, 1'b0);
        chk("R12", "arvalid cycles", r_n_ar, int'(v.d_a) + 1);
        chk("R3", "no dst strobe on read", r_n_dst, 0);
        if (v.lock) chk("R9", "locked read done", r_done, 1'b1);
      end
      chk("R10", "prot during run", {m_arprot, m_awprot, cmd_rearb, cmd_tmo}, 8'b0);
    end

    // R13 zero-wait latency
    set_slave(0, 0, 0, 2'b00, 32'h0000_1111);
    run_cmd(1'b0, 1'b0, 1'b0, 32'h1000_0100, 32'h0, 4'h0, -1);
    chk("R13", "read ack cycle", r_k_ack, 1);
    chk("R13", "read done cycle", r_k_done, 2);
    run_cmd(1'b1, 1'b0, 1'b0, 32'h2000_0100, 32'h2222_3333, 4'h3, -1);
    chk("R13", "write ack cycle", r_k_ack, 1);
    chk("R13", "write dst cycle", r_k_dst, 1);
    chk("R13", "write done cycle", r_k_done, 2);

    // R8 simultaneous read and write: read wins, write dropped
    set_slave(1, 0, 1, 2'b00, 32'h4444_5555);
    run_cmd(1'b0, 1'b1, 1'b0, 32'h1000_0200, 32'h9999_9999, 4'hC, -1);
    chk("R8", "read taken", r_rd, 32'h4444_5555);
    chk("R8", "no AW during read", r_n_aw, 0);
    chk("R8", "one ack", r_n_ack, 1);
    // R9 byte enables ignored on reads: strobes keep last write's 0011
    chk("R9", "wstrb held on read", r_wstrb0, 4'h3);
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (m_awvalid || m_wvalid || m_arvalid) seen++;
      end
      chk("R8", "dropped write never issued", seen, 0);
    end

    // R8 request while busy is ignored
    set_slave(6, 0, 0, 2'b00, 32'h6666_7777);
    run_cmd(1'b0, 1'b0, 1'b0, 32'h1000_0300, 32'h0, 4'h0, 2);
    chk("R8", "busy read completes", r_rd, 32'h6666_7777);
    chk("R8", "one ack while busy", r_n_ack, 1);
    chk("R8", "no AW from busy req", r_n_aw, 0);
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (m_awvalid || cmd_ack) seen++;
      end
      chk("R8", "ignored req stays ignored", seen, 0);
    end

    // R11 hard reset during a stalled write
    set_slave(15, 15, 0, 2'b00, 32'h0);
    @(negedge clk);
    cmd_addr = 32'h2000_0400; wr_data = 32'hABCD_EF01; cmd_be = 4'h6; wr_req = 1;
    @(negedge clk);
    wr_req = 0;
    @(negedge clk);
    chk("R11", "write stalled", {m_awvalid, m_wvalid}, 2'b11);
    rst = 1;
    begin
      int dones;
      dones = 0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (cmd_done) dones++;
        if (c == 0) begin
          chk("R11", "valids dropped", {m_awvalid, m_wvalid, m_bready}, 3'b0);
          chk("R1", "wstrb back to ones", m_wstrb, 4'hF);
          chk("R7", "md cleared by rst", md_error, 1'b0);
        end
      end
      chk("R11", "no completion", dones, 0);
    end
    rst = 0;
    set_slave(0, 0, 0, 2'b00, 32'h0BB0_0CC0);
    run_cmd(1'b0, 1'b0, 1'b0, 32'h1000_0500, 32'h0, 4'h0, -1);
    chk("R11", "works after reset", r_rd, 32'h0BB0_0CC0);

    // R7 sticky error cleared by usr_rst
    set_slave(0, 0, 0, 2'b11, 32'h0);
    run_cmd(1'b0, 1'b0, 1'b0, 32'h1000_0600, 32'h0, 4'h0, -1);
    repeat (3) @(negedge clk);
    chk("R7", "md held while idle", md_error, 1'b1);
    usr_rst = 1;
    @(negedge clk);
    usr_rst = 0;
    chk("R7", "md cleared by usr_rst", md_error, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule